// File: doc/BRIEF.md
# Multiply Cycle and Bus-Type Sequencer

This block sits on the execute side of a pipelined integer core and paces multiply instructions. A decoder hands it a two-bit multiply class, a flag-update bit, an interlock bit and the program counter of the instruction. The block then holds the instruction for as many execute cycles as that combination needs.

In every one of those cycles it drives a transfer-type code and the fetch address. The fetch address is the program counter advanced by three instruction steps, and it is the same in every cycle of the instruction. All cycles except the final one are internal cycles. The final cycle is a sequential fetch, and `done_o` is high only in that cycle. A new instruction can be taken while the block is idle, or in the cycle that carries `done_o`, so multiplies can run back to back with no gap.

The arithmetic, the decode and the decision whether an interlock applies are made elsewhere.

Top module: `mul_cycle_seq`

## Requirements
- R1: Class 00 (32-bit multiply/accumulate) lasts 2 cycles, or 3 cycles when the interlock bit is set. With the flag-update bit set it lasts 4 cycles whatever the interlock bit is.
- R2: Class 01 (64-bit long multiply/accumulate) lasts 3 cycles, or 4 cycles when interlocked. With the flag-update bit set it lasts 5 cycles whatever the interlock bit is.
- R3: Class 10 (halfword and word-by-halfword multiply/accumulate) lasts 1 cycle, or 2 cycles when interlocked. The flag-update bit has no effect on it.
- R4: Class 11 (long halfword accumulate) lasts 2 cycles, or 3 cycles when interlocked. The flag-update bit has no effect on it.
- R5: `trans_o` is 2'b00 (internal) in every cycle of an instruction except the last, and 2'b10 (sequential) in the last. A 1-cycle instruction shows only 2'b10.
- R6: `done_o` is high in the last cycle of an instruction and in no other cycle.
- R7: While `busy_o` is high, `addr_o` equals the accepted `pc_i` plus 3*`INSTR_STEP` (modulo 2^`ADDR_W`), and it does not change within an instruction.
- R8: `start_i` is accepted only when the block is idle or `done_o` is high. An accepted start makes the instruction's first cycle begin after the next clock edge, with no idle cycle in between. A start seen in any other cycle has no effect.
- R9: The class, flag-update bit, interlock bit and `pc_i` are sampled only at acceptance. Changing them later does not alter the running instruction.
- R10: During reset and while idle: `busy_o`=0, `done_o`=0, `trans_o`=2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to begin a multiply instruction |
| class_i | input | 2 | Multiply class: 00 32-bit, 01 long 64-bit, 10 halfword, 11 long halfword accumulate |
| setflags_i | input | 1 | Instruction updates condition flags |
| interlock_i | input | 1 | Instruction is interlocked on a prior multiply result |
| pc_i | input | ADDR_W | Program counter of the instruction |
| busy_o | output | 1 | An instruction is in progress |
| trans_o | output | 2 | Transfer type: 00 internal/idle, 10 sequential |
| addr_o | output | ADDR_W | Fetch address, pc plus three steps |
| done_o | output | 1 | Last cycle of the instruction |

## Verification
The bench builds the block with its defaults: a 32-bit address and a step of 4. The 32-bit width lets random program counters near the top of the space reach the address wrap. The 3-bit counter covers the longest 5-cycle flag-setting long multiply, so every class, flag and interlock combination runs to completion. Back-to-back chains, idle gaps and inputs changed mid-instruction all occur, and this exercises acceptance in the done cycle and the rejection of starts in every other cycle.

// File: rtl/mul_seq_pkg.sv
package mul_seq_pkg;
  typedef enum logic [1:0] {
    MC_W32  = 2'b00,
    MC_L64  = 2'b01,
    MC_HW   = 2'b10,
    MC_HWL  = 2'b11
  } mul_class_e;

  typedef enum logic [1:0] {
    TT_INT = 2'b00,
    TT_SEQ = 2'b10
  } trans_e;

  localparam int unsigned MAX_CYCLES = 5;
endpackage

// File: rtl/mul_cycle_calc.sv
module mul_cycle_calc
  import mul_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic [1:0]       class_i,
  input  logic             setflags_i,
  input  logic             interlock_i,
  output logic [CNT_W-1:0] cycles_o
);
  logic [CNT_W-1:0] base;
  logic             flag_class;

  always_comb begin
    unique case (mul_class_e'(class_i))
      MC_W32:  base = CNT_W'(2);
      MC_L64:  base = CNT_W'(3);
      MC_HW:   base = CNT_W'(1);
      default: base = CNT_W'(2);
    endcase
  end

  // flag update only stretches full-width classes
  assign flag_class = (class_i == MC_W32) || (class_i == MC_L64);

  always_comb begin
    if (flag_class && setflags_i)
      cycles_o = base + CNT_W'(2);
    else
      cycles_o = base + CNT_W'(interlock_i);
  end
endmodule

// File: rtl/mul_cycle_ctr.sv
module mul_cycle_ctr #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign busy_o   = (cnt_q != '0);
  assign last_o   = (cnt_q == CNT_W'(1));
  assign accept_o = start_i && (!busy_o || last_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (accept_o) cnt_q <= load_i;
    else if (busy_o)   cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/mul_bus_drv.sv
module mul_bus_drv
  import mul_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSTR_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              busy_i,
  input  logic              last_i,
  output logic [1:0]        trans_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] FETCH_OFS = ADDR_W'(3 * INSTR_STEP);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (accept_i) addr_q <= pc_i + FETCH_OFS;
  end

  assign addr_o  = addr_q;
  assign trans_o = (busy_i && last_i) ? TT_SEQ : TT_INT;
endmodule

// File: rtl/mul_cycle_seq.sv
module mul_cycle_seq
  import mul_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned INSTR_STEP = 4,
  parameter int unsigned CNT_W      = $clog2(MAX_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        class_i,
  input  logic              setflags_i,
  input  logic              interlock_i,
  input  logic [ADDR_W-1:0] pc_i,
  output logic              busy_o,
  output logic [1:0]        trans_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  logic [CNT_W-1:0] cycles;
  logic             accept, busy, last;

  mul_cycle_calc #(.CNT_W(CNT_W)) u_calc (
    .class_i     (class_i),
    .setflags_i  (setflags_i),
    .interlock_i (interlock_i),
    .cycles_o    (cycles)
  );

  mul_cycle_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .load_i   (cycles),
    .accept_o (accept),
    .busy_o   (busy),
    .last_o   (last)
  );

  mul_bus_drv #(.ADDR_W(ADDR_W), .INSTR_STEP(INSTR_STEP)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .pc_i     (pc_i),
    .busy_i   (busy),
    .last_i   (last),
    .trans_o  (trans_o),
    .addr_o   (addr_o)
  );

  assign busy_o = busy;
  assign done_o = busy && last;
endmodule

// File: rtl/mul_cycle_seq_chk.sv
module mul_cycle_seq_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic [1:0]        trans_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);
  logic       acc;
  logic [3:0] len_q;

  assign acc = start_i && (!busy_o || done_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (acc)    len_q <= 4'd1;
    else if (busy_o) len_q <= len_q + 4'd1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (trans_o == 2'b00 && !done_o)); // R10
  AST_SEQ_ONLY_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && trans_o == 2'b10) |-> done_o); // R5
  AST_DONE_IS_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> trans_o == 2'b10); // R6
  AST_TRANS_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trans_o == 2'b00 || trans_o == 2'b10); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(addr_o)); // R7
  AST_ACCEPT_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> busy_o); // R8
  AST_MID_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o); // R8
  AST_MAX_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (len_q >= 4'd1 && len_q <= 4'd5)); // R2
endmodule

bind mul_cycle_seq mul_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .busy_o  (busy_o),
  .trans_o (trans_o),
  .addr_o  (addr_o),
  .done_o  (done_o)
);

// File: tb/tb_mul_cycle_seq.sv
module tb_mul_cycle_seq;
  localparam int unsigned AW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    class_i = '0;
  logic          setflags_i = 1'b0;
  logic          interlock_i = 1'b0;
  logic [AW-1:0] pc_i = '0;
  logic          busy_o, done_o;
  logic [1:0]    trans_o;
  logic [AW-1:0] addr_o;

  int errs = 0;
  int checks = 0;
  int seed = 32'h5eed_1234;

  always #4 clk_i = ~clk_i;

  mul_cycle_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .class_i(class_i),
    .setflags_i(setflags_i), .interlock_i(interlock_i), .pc_i(pc_i),
    .busy_o(busy_o), .trans_o(trans_o), .addr_o(addr_o), .done_o(done_o)
  );

  function automatic int exp_cycles(input logic [1:0] c, input logic sf, input logic il);
    case (c)
      2'b00:   return sf ? 4 : 2 + int'(il);
      2'b01:   return sf ? 5 : 3 + int'(il);
      2'b10:   return 1 + int'(il);
      default: return 2 + int'(il);
    endcase
  endfunction

  function automatic string req_of(input logic [1:0] c);
    case (c)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_cycle();
    start_i = 1'b0;
    @(posedge clk_i); #1;
    chk("R10 idle busy", 64'(busy_o), 64'd0);
    chk("R10 idle trans", 64'(trans_o), 64'd0);
    chk("R10 idle done", 64'(done_o), 64'd0);
  endtask

  // Called at posedge+1, block idle or in done cycle
  task automatic run(input logic [1:0] c, input logic sf, input logic il,
                     input logic [AW-1:0] pc, input bit noise);
    int n;
    logic [AW-1:0] ea;
    n  = exp_cycles(c, sf, il);
    ea = pc + AW'(12);
    start_i = 1'b1; class_i = c; setflags_i = sf; interlock_i = il; pc_i = pc;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    for (int k = 1; k <= n; k++) begin
      chk({req_of(c), " busy"}, 64'(busy_o), 64'd1);
      chk("R5 trans", 64'(trans_o), (k == n) ? 64'h2 : 64'h0);
      chk("R6 done", 64'(done_o), (k == n) ? 64'd1 : 64'd0);
      chk("R7 addr", 64'(addr_o), 64'(ea));
      if (k < n) begin
        if (noise) begin
          // R8 R9: late start and changed fields must not disturb
          start_i = 1'b1; class_i = 2'($urandom());
          setflags_i = ~sf; interlock_i = ~il; pc_i = $urandom();
        end
        @(posedge clk_i); #1;
        start_i = 1'b0;
      end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : main
    void'($urandom(seed));
    start_i = 1'b1;
    #3;
    chk("R10 reset busy", 64'(busy_o), 64'd0);
    chk("R10 reset trans", 64'(trans_o), 64'd0);
    chk("R10 reset done", 64'(done_o), 64'd0);
    repeat (2) @(posedge clk_i);
    #1;
    chk("R10 reset start ignored", 64'(busy_o), 64'd0);
    start_i = 1'b0;
    rst_ni = 1'b1;
    idle_cycle();

    // directed: every class/flag/interlock combination
    for (int c = 0; c < 4; c++)
      for (int f = 0; f < 2; f++)
        for (int i = 0; i < 2; i++) begin
          run(2'(c), f[0], i[0], AW'(32'h100 * (c + 1)), 1'b0);
          idle_cycle();
        end

    // R3: single-cycle chain, back to back, then sequential-only check
    run(2'b10, 1'b1, 1'b0, 32'h0000_0040, 1'b0);
    run(2'b10, 1'b0, 1'b0, 32'h0000_0044, 1'b0);
    run(2'b11, 1'b1, 1'b0, 32'h0000_0048, 1'b1);
    idle_cycle();

    // R7: address wrap
    run(2'b01, 1'b1, 1'b1, 32'hFFFF_FFF8, 1'b1);
    idle_cycle();

    // R8 R9: noisy longest instruction
    run(2'b01, 1'b1, 1'b0, 32'h1234_5670, 1'b1);
    idle_cycle();

    // random mix
    for (int t = 0; t < 400; t++) begin
      run(2'($urandom()), 1'($urandom()), 1'($urandom()), $urandom(), 1'($urandom()));
      if ($urandom_range(0, 3) == 0) idle_cycle();
    end
    idle_cycle();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule